// File: doc/BRIEF.md
# Protected System Clock Controller

This block picks the system clock from a set of candidate sources and divides it through a chain of three power-of-two prescaler stages. Each source is modelled by a ready flag and a tick strobe in a fast reference clock domain. All outputs are single-cycle clock-enable strobes in that domain. The final stage gives the CPU rate. The outputs of the first and second stages give the faster enables that peripherals running above the CPU rate use.

Configuration goes through a small register bus with a write port and a combinational read port. The source, divider and lock registers are guarded. A write to any of them is accepted only inside a short window. That window is opened by writing a fixed key byte to the key register, and it admits exactly one guarded write. Requests for a source that is not ready, and divider combinations that are not allowed, are refused and the old setting is kept. A lock bit freezes the whole configuration until reset. An external oscillator-failure event clears the lock.

A new divider setting waits until every stage counter has wrapped before it takes effect. Because of this, no CPU-rate period shorter than both the old and the new period can appear.

Top module: `prot_clk_ctrl`

## Requirements
- R1: After reset, source 1 is selected, the divider register reads 0 (all stages divide by 1) and the lock reads 0, so `cpu_en` fires once per selected source tick.
- R2: The divider register sits at address 2, with stage-A exponent a in bits [3:0], stage-B exponent b in bits [5:4] and stage-C exponent c in bit 6. The `cpu_en` period is the selected source's tick period times 2^(a+b+c).
- R3: `x4_en` is the stage-A output and `x2_en` is the stage-B output. Within one `cpu_en` period, `x4_en` fires 2^(b+c) times and `x2_en` fires 2^c times.
- R4: Writing 0xD8 to address 0 opens a write window that lasts 4 CPU-rate strobes. A write to address 1, 2 or 3 outside an open window is ignored.
- R5: A window admits one guarded write only. A second guarded write under the same key is ignored.
- R6: The source register sits at address 1, bits [2:0]. Selecting a source whose ready flag is low, or an index of NUM_SRC or more, is ignored.
- R7: A divider write with a > 9, b = 3 or b + c > 2 is rejected, and the previous divider value stays in effect.
- R8: A guarded write of 1 to bit 0 of address 3 sets the lock. While the lock is set, every guarded write is ignored.
- R9: A one-cycle pulse on `fail_evt` clears the lock.
- R10: An accepted divider change takes effect only when all stage counters wrap. The `cpu_en` interval that spans the change equals the old period, and the new period follows from the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_rdy | input | NUM_SRC | Per-source ready flags |
| src_tick | input | NUM_SRC | Per-source tick strobes |
| fail_evt | input | 1 | Oscillator failure event; clears the lock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 key, 1 source, 2 divider, 3 lock) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (key address reads 0) |
| cpu_en | output | 1 | CPU-rate enable strobe |
| x2_en | output | 1 | Stage-B output enable strobe |
| x4_en | output | 1 | Stage-A output enable strobe |

## Verification
A wrong divider counter or a setting applied mid-count shows up at `cpu_en` within one period: the interval is too short, or it does not match the programmed product. A wrong sub-rate count appears in the `x2_en`/`x4_en` pulses counted inside that same period. A window that stays open too long, or one that admits a second write, shows at the read port on the next access as a register value that should have been refused. A lock that leaks or never clears shows the same way. Sweeping every divider code against measured periods catches both arithmetic faults and faults in accepting or rejecting a setting.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_SRC  = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_LOCK = 2'd3;

  typedef struct packed {
    logic       c_log;
    logic [1:0] b_log;
    logic [3:0] a_log;
  } div_cfg_t;

  // combined B and C exponent may not exceed 2 (divide by 4)
  function automatic logic div_cfg_ok(div_cfg_t c, int a_max);
    logic [2:0] bc;
    bc = {1'b0, c.b_log} + {2'b00, c.c_log};
    return (int'(c.a_log) <= a_max) && (c.b_log != 2'd3) && (bc <= 3'd2);
  endfunction

endpackage

// File: rtl/pclk_div_stage.sv
module pclk_div_stage #(
  parameter int LOG_MAX = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic [3:0] log_sel,
  output logic       tick_out,
  output logic       at_zero
);
  localparam int CW = (LOG_MAX < 1) ? 1 : LOG_MAX;

  logic [CW-1:0] cnt;
  logic [CW-1:0] term;

  assign term     = CW'((32'd1 << log_sel) - 32'd1);
  assign tick_out = tick_in && (cnt == term);
  assign at_zero  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (tick_in) cnt <= tick_out ? '0 : cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= term); // R10

endmodule

// File: rtl/pclk_prescaler.sv
module pclk_prescaler
  import pclk_pkg::*;
#(
  parameter int A_MAX = 9
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     src_tick,
  input  div_cfg_t cfg_in,
  input  logic     cfg_load,
  output logic     tick_4x,
  output logic     tick_2x,
  output logic     tick_cpu,
  output div_cfg_t cfg_act,
  output logic     wrap_ok
);
  localparam int NSTG = 3;

  logic [NSTG:0]   chain;
  logic [NSTG-1:0] zero;
  logic [3:0]      lg [NSTG];
  div_cfg_t        cfg_pend;
  logic            pend;
  logic [2:0]      bc_sum;

  assign lg[0]    = cfg_act.a_log;
  assign lg[1]    = {2'b00, cfg_act.b_log};
  assign lg[2]    = {3'b000, cfg_act.c_log};
  assign chain[0] = src_tick;

  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
      localparam int LM = (g == 0) ? A_MAX : (g == 1) ? 2 : 1;
      pclk_div_stage #(.LOG_MAX(LM)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (chain[g]),
        .log_sel  (lg[g]),
        .tick_out (chain[g+1]),
        .at_zero  (zero[g])
      );
    end
  endgenerate

  assign tick_4x  = chain[1];
  assign tick_2x  = chain[2];
  assign tick_cpu = chain[3];
  // safe switch point: all counters wrap now, or all idle at zero
  assign wrap_ok  = tick_cpu || ((&zero) && !src_tick);
  assign bc_sum   = {1'b0, cfg_act.b_log} + {2'b00, cfg_act.c_log};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_act  <= '0;
      cfg_pend <= '0;
      pend     <= 1'b0;
    end else begin
      if (pend && wrap_ok) begin
        cfg_act <= cfg_pend;
        pend    <= 1'b0;
      end
      if (cfg_load) begin
        cfg_pend <= cfg_in;
        pend     <= 1'b1;
      end
    end
  end

  AST_CFG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act != $past(cfg_act)) |-> $past(wrap_ok)); // R10
  AST_BC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bc_sum <= 3'd2); // R7

endmodule

// File: rtl/pclk_protect.sv
module pclk_protect
  import pclk_pkg::*;
#(
  parameter int         WIN_LEN = 4,
  parameter logic [7:0] KEY     = 8'hD8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       cpu_pulse,
  input  logic       fail_evt,
  output logic       prot_wr,
  output logic       locked,
  output logic       win_open
);
  localparam int WW = $clog2(WIN_LEN + 1);

  logic [WW-1:0] win_cnt;
  logic          key_hit;
  logic          lock_set;

  assign key_hit  = wr_en && (wr_addr == ADDR_KEY) && (wr_data == KEY);
  assign win_open = (win_cnt != '0);
  assign prot_wr  = wr_en && (wr_addr != ADDR_KEY) && win_open && !locked;
  assign lock_set = prot_wr && (wr_addr == ADDR_LOCK) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     win_cnt <= '0;
    else if (key_hit)               win_cnt <= WW'(WIN_LEN);
    else if (prot_wr)               win_cnt <= '0;
    else if (cpu_pulse && win_open) win_cnt <= win_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b0;
    else if (fail_evt) locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr |=> !win_open); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !fail_evt) |=> locked); // R8
  AST_FAIL_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> !locked); // R9

endmodule

// File: rtl/prot_clk_ctrl.sv
module prot_clk_ctrl
  import pclk_pkg::*;
#(
  parameter int NUM_SRC   = 5,
  parameter int RESET_SRC = 1,
  parameter int A_MAX     = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_rdy,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               fail_evt,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [1:0]         rd_addr,
  output logic [7:0]         rd_data,
  output logic               cpu_en,
  output logic               x2_en,
  output logic               x4_en
);
  localparam int SRC_W = (NUM_SRC < 2) ? 1 : $clog2(NUM_SRC);

  logic [SRC_W-1:0] cur_src;
  logic             sel_tick;
  logic             prot_wr, locked, win_open;
  logic             src_ok, div_ok;
  logic             t4, t2, tc, wrap_ok;
  div_cfg_t         cfg_new, cfg_act;

  assign sel_tick = src_tick[cur_src];
  assign cfg_new  = div_cfg_t'(wr_data[6:0]);
  assign src_ok   = prot_wr && (wr_addr == ADDR_SRC) && (int'(wr_data) < NUM_SRC)
                    && src_rdy[wr_data[SRC_W-1:0]];
  assign div_ok   = prot_wr && (wr_addr == ADDR_DIV) && div_cfg_ok(cfg_new, A_MAX);

  pclk_protect #(.WIN_LEN(4), .KEY(8'hD8)) u_protect (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cpu_pulse (tc),
    .fail_evt  (fail_evt),
    .prot_wr   (prot_wr),
    .locked    (locked),
    .win_open  (win_open)
  );

  pclk_prescaler #(.A_MAX(A_MAX)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (sel_tick),
    .cfg_in   (cfg_new),
    .cfg_load (div_ok),
    .tick_4x  (t4),
    .tick_2x  (t2),
    .tick_cpu (tc),
    .cfg_act  (cfg_act),
    .wrap_ok  (wrap_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_src <= SRC_W'(RESET_SRC);
    else if (src_ok) cur_src <= wr_data[SRC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en <= 1'b0;
      x2_en  <= 1'b0;
      x4_en  <= 1'b0;
    end else begin
      cpu_en <= tc;
      x2_en  <= t2;
      x4_en  <= t4;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_SRC:  rd_data = 8'(cur_src);
      ADDR_DIV:  rd_data = {1'b0, cfg_act};
      ADDR_LOCK: rd_data = {7'b0, locked};
      default:   rd_data = 8'h00;
    endcase
  end

  AST_SRC_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_src != $past(cur_src)) |-> $past(src_rdy[cur_src])); // R6
  AST_SRC_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_src != $past(cur_src)) |-> $past(win_open && !locked)); // R4

endmodule

// File: tb/test_prot_clk_ctrl.sv
module test_prot_clk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 5;
  localparam int WD_CYCLES  = 190000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_rdy = '0;
  logic [NSRC-1:0] src_tick = '0;
  logic            fail_evt = 1'b0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = '0;
  logic [7:0]      wr_data = '0;
  logic [1:0]      rd_addr = '0;
  logic [7:0]      rd_data;
  logic            cpu_en, x2_en, x4_en;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;

  prot_clk_ctrl #(.NUM_SRC(NSRC), .RESET_SRC(1), .A_MAX(9)) i_prot_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .src_rdy(src_rdy), .src_tick(src_tick),
    .fail_evt(fail_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cpu_en(cpu_en), .x2_en(x2_en), .x4_en(x4_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int src_per(int i);
    return (i == 1) ? 1 : i + 1;
  endfunction

  always @(negedge clk)
    for (int i = 0; i < NSRC; i++) src_tick[i] <= ((cyc % src_per(i)) == 0);

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic key();
    wr(2'd0, 8'hD8);
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk); rd_addr = a; #1 v = int'(rd_data);
  endtask

  task automatic next_pulse(output int t);
    do @(negedge clk); while (!cpu_en);
    t = cyc;
  endtask

  task automatic measure(output int per, output int n2, output int n4);
    int t0;
    next_pulse(t0);
    n2 = 0; n4 = 0;
    do begin
      @(negedge clk);
      if (x2_en) n2++;
      if (x4_en) n4++;
    end while (!cpu_en);
    per = cyc - t0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    vectors++; misses++;
    $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    finish_run();
  end

  initial begin
    int v, per, n2, n4, t, t0, t1, t2, prev, cfg;
    logic legal;
    src_rdy = 5'b10111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd1, v); chk("R1 src", v, 1);
    rd(2'd2, v); chk("R1 div", v, 0);
    rd(2'd3, v); chk("R1 lock", v, 0);
    measure(per, n2, n4);
    chk("R1 period", per, 1);

    // R2 R3 R7 sweep over all divider codes
    prev = 0;
    for (int a = 0; a <= 10; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++) begin
          cfg = (c << 6) | (b << 4) | a;
          legal = (a <= 9) && (b != 3) && (b + c <= 2);
          key(); wr(2'd2, 8'(cfg));
          if (legal) begin
            next_pulse(t);
            measure(per, n2, n4);
            chk("R2 period", per, 1 << (a + b + c));
            chk("R3 x4 count", n4, 1 << (b + c));
            chk("R3 x2 count", n2, 1 << c);
            rd(2'd2, v); chk("R7 legal readback", v, cfg);
            prev = cfg;
          end else begin
            rd(2'd2, v); chk("R7 rejected", v, prev);
          end
        end
    key(); wr(2'd2, 8'd0); next_pulse(t); next_pulse(t);

    // R10 change applied only at wrap
    key(); wr(2'd2, 8'd3); next_pulse(t); next_pulse(t0);
    repeat (3) @(negedge clk);
    key(); wr(2'd2, 8'd0);
    next_pulse(t1); chk("R10 spanning interval", t1 - t0, 8);
    next_pulse(t2); chk("R10 new interval", t2 - t1, 1);

    // R4 window and key
    key(); wr(2'd2, 8'd2); next_pulse(t); next_pulse(t);
    wr(2'd1, 8'd2); rd(2'd1, v); chk("R4 no key", v, 1);
    next_pulse(t); key();
    repeat (4) next_pulse(t);
    wr(2'd1, 8'd0); rd(2'd1, v); chk("R4 expired", v, 1);
    next_pulse(t); key();
    repeat (3) next_pulse(t);
    wr(2'd1, 8'd0); rd(2'd1, v); chk("R4 inside window", v, 0);
    key(); wr(2'd1, 8'd1);

    // R6 source readiness
    key(); wr(2'd1, 8'd3); rd(2'd1, v); chk("R6 unready", v, 1);
    key(); wr(2'd1, 8'd7); rd(2'd1, v); chk("R6 out of range", v, 1);
    src_rdy[3] = 1'b1;
    key(); wr(2'd1, 8'd3); rd(2'd1, v); chk("R6 ready accepted", v, 3);
    measure(per, n2, n4); chk("R6 period src3", per, 16);
    key(); wr(2'd1, 8'd1);

    // R5 one write per key
    key(); wr(2'd2, 8'd3); next_pulse(t); next_pulse(t);
    key(); wr(2'd1, 8'd2); wr(2'd2, 8'd0);
    next_pulse(t); next_pulse(t);
    rd(2'd2, v); chk("R5 second write", v, 3);
    rd(2'd1, v); chk("R5 first write", v, 2);

    // R8 lock
    key(); wr(2'd3, 8'd1); rd(2'd3, v); chk("R8 lock set", v, 1);
    key(); wr(2'd1, 8'd1); rd(2'd1, v); chk("R8 src frozen", v, 2);
    key(); wr(2'd2, 8'd0); next_pulse(t); next_pulse(t);
    rd(2'd2, v); chk("R8 div frozen", v, 3);

    // R9 failure clears lock
    @(negedge clk); fail_evt = 1'b1;
    @(negedge clk); fail_evt = 1'b0;
    rd(2'd3, v); chk("R9 lock cleared", v, 0);
    key(); wr(2'd1, 8'd1); rd(2'd1, v); chk("R9 writes resume", v, 1);

    finish_run();
  end

endmodule